// File: doc/BRIEF.md
# Video Front-End Configuration Slave (Two-Wire Serial)

This block is a two-wire (I2C-style) serial slave that keeps the configuration words for a three-channel video capture front end. A host on the serial bus addresses the slave, sets an internal register pointer and then writes or reads a run of registers. The pointer advances by one after every data byte. Each colour channel has a gain word and an offset word. Two further words set where the clamp pulse starts and how long it lasts. Every stored value is driven out continuously as a parallel bus to the datapath.

The seven-bit slave address has two parts. Its upper bits come from a parameter and its two lowest bits come from two select pins, so up to four slaves can share one bus. SCL and SDA are brought into the core clock domain through flop synchronizers. The protocol engine is a state machine that runs on the detected SCL edges and on the START and STOP conditions. SDA is open-drain: the block only ever requests that the line be pulled low.

The machine has seven states:
- `ST_IDLE` waits for START.
- `ST_ADDR` shifts in the address byte.
- `ST_ADDR_ACK` acknowledges a matching address.
- `ST_WR_BYTE` shifts in a pointer or data byte.
- `ST_WR_ACK` acknowledges that byte.
- `ST_RD_BYTE` shifts out a register.
- `ST_RD_ACK` samples the host's acknowledge.

Transitions:
- START takes any state to `ST_ADDR`.
- STOP takes any state to `ST_IDLE`.
- `ST_ADDR` goes to `ST_ADDR_ACK` after the eighth bit if the address matches, and to `ST_IDLE` if it does not.
- `ST_ADDR_ACK` goes to `ST_RD_BYTE` when the read bit is set, and to `ST_WR_BYTE` otherwise.
- `ST_WR_BYTE` goes to `ST_WR_ACK` after eight bits, and `ST_WR_ACK` goes back to `ST_WR_BYTE`.
- `ST_RD_BYTE` goes to `ST_RD_ACK` after eight bits.
- `ST_RD_ACK` goes to `ST_RD_BYTE` on an acknowledge and to `ST_IDLE` on a not-acknowledge.

Top module: `vcfg_i2c_regs`

## Requirements
- R1: After reset every register holds 80h: each gain, clamp start and clamp length output reads 80h, each 6-bit offset output reads 20h, and SDA is not pulled low.
- R2: The slave acknowledges an address byte only when its upper seven bits equal {DEV_BASE[6:2], dev_sel}, with bit 0 as the read flag (1 = read). On any other address it does not acknowledge and ignores the bus until the next START.
- R3: The first byte after a write address is acknowledged and loaded into the register pointer.
- R4: Every later byte of a write is acknowledged, stored in the pointed register, and then the pointer increments. The map is: 02h red gain, 03h green gain, 04h blue gain, 08h clamp start, 09h clamp length.
- R5: Registers 05h, 06h and 07h (red, green, blue offset) keep only bits 7:2 of the written byte and drive them as a 6-bit output. A read returns those bits in 7:2 with bits 1:0 as zero.
- R6: A read sends the pointed register MSB first and increments the pointer after each byte. The pointer wraps from FFh to 00h. A host not-acknowledge ends the read.
- R7: A write to a pointer outside 02h–09h changes nothing, and a read of such a pointer returns 00h. The pointer still increments in both cases.
- R8: A START in any state restarts the address phase, including a repeated START inside a transfer. A STOP in any state returns to idle and discards a partly received byte.
- R9: SDA is pulled low only during an acknowledge bit sent by the slave and during zero data bits of a read. It is never pulled low during a transfer to another address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Serial data line level, asynchronous |
| dev_sel | input | 2 | Low two slave-address bits |
| sda_pull_low | output | 1 | Pull SDA low when 1 (open-drain) |
| gain_r | output | 8 | Red gain word |
| gain_g | output | 8 | Green gain word |
| gain_b | output | 8 | Blue gain word |
| ofst_r | output | 6 | Red offset word |
| ofst_g | output | 6 | Green offset word |
| ofst_b | output | 6 | Blue offset word |
| clamp_start | output | 8 | Clamp start position in pixels |
| clamp_len | output | 8 | Clamp length in pixels |

## Verification
The bench uses the default parameters: address base 4Ch, two select pins, a 6-bit offset field and two synchronizer stages. With these values the whole 7-bit address space is small enough to sweep in full, and all four select-pin values can be tried. The 8-bit pointer space can also be read end to end in one burst, which covers every unmapped location and the wrap from FFh to 00h. The bench keeps its own model of the register bytes, masks the offset bytes arithmetically, and predicts every read byte and parallel output from that model.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } link_state_t;

    localparam int NCH = 3;
    localparam int BYTE_W = 8;

    localparam logic [7:0] REG_GAIN_BASE = 8'h02;
    localparam logic [7:0] REG_OFST_BASE = 8'h05;
    localparam logic [7:0] REG_CLAMP_POS = 8'h08;
    localparam logic [7:0] REG_CLAMP_LEN = 8'h09;
    localparam logic [7:0] REG_FIRST     = 8'h02;
    localparam logic [7:0] REG_LAST      = 8'h09;

endpackage

// File: rtl/vcfg_sync.sv
module vcfg_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/vcfg_regfile.sv
module vcfg_regfile
    import vcfg_pkg::*;
#(
    parameter int         OFST_W  = 6,
    parameter logic [7:0] RST_VAL = 8'h80
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [7:0]              wr_addr,
    input  logic [7:0]              wr_data,
    input  logic [7:0]              rd_addr,
    output logic [7:0]              rd_data,
    output logic [NCH*BYTE_W-1:0]   gain_bus,
    output logic [NCH*OFST_W-1:0]   ofst_bus,
    output logic [7:0]              clamp_pos,
    output logic [7:0]              clamp_len
);
    localparam int PAD_W = BYTE_W - OFST_W;

    logic [BYTE_W-1:0] gain_q [NCH];
    logic [OFST_W-1:0] ofst_q [NCH];
    logic [7:0]        pos_q, len_q;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                gain_q[ch] <= RST_VAL;
                ofst_q[ch] <= RST_VAL[BYTE_W-1 -: OFST_W];
            end else if (wr_en) begin
                if (wr_addr == REG_GAIN_BASE + 8'(ch)) gain_q[ch] <= wr_data;
                if (wr_addr == REG_OFST_BASE + 8'(ch)) ofst_q[ch] <= wr_data[BYTE_W-1 -: OFST_W];
            end
        end
        assign gain_bus[ch*BYTE_W +: BYTE_W] = gain_q[ch];
        assign ofst_bus[ch*OFST_W +: OFST_W] = ofst_q[ch];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= RST_VAL;
            len_q <= RST_VAL;
        end else if (wr_en) begin
            if (wr_addr == REG_CLAMP_POS) pos_q <= wr_data;
            if (wr_addr == REG_CLAMP_LEN) len_q <= wr_data;
        end
    end

    assign clamp_pos = pos_q;
    assign clamp_len = len_q;

    always_comb begin
        rd_data = 8'h00;
        for (int c = 0; c < NCH; c++) begin
            if (rd_addr == REG_GAIN_BASE + 8'(c)) rd_data = gain_q[c];
            if (rd_addr == REG_OFST_BASE + 8'(c)) rd_data = {ofst_q[c], {PAD_W{1'b0}}};
        end
        if (rd_addr == REG_CLAMP_POS) rd_data = pos_q;
        if (rd_addr == REG_CLAMP_LEN) rd_data = len_q;
    end

    AST_UNMAPPED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr < REG_FIRST || wr_addr > REG_LAST)) |=>
            ($stable(gain_bus) && $stable(ofst_bus) && $stable(clamp_pos) && $stable(clamp_len))); // R7

    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(gain_bus) && $stable(ofst_bus) && $stable(clamp_pos) && $stable(clamp_len))); // R4
endmodule

// File: rtl/vcfg_link.sv
module vcfg_link
    import vcfg_pkg::*;
#(
    parameter logic [6:0] DEV_BASE = 7'h4C,
    parameter int         SEL_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_s,
    input  logic             sda_s,
    input  logic [SEL_W-1:0] dev_sel,
    input  logic [7:0]       rd_data,
    output logic             wr_en,
    output logic [7:0]       wr_addr,
    output logic [7:0]       wr_data,
    output logic [7:0]       rd_addr,
    output logic             sda_low
);
    localparam logic [3:0] BITS_PER_BYTE = 4'd8;
    localparam logic [3:0] LAST_TX_BIT   = 4'd7;

    link_state_t state, nxt;
    logic        scl_d, sda_d;
    logic [3:0]  cnt;
    logic [7:0]  shreg, tx, ptr;
    logic        rw, ptr_phase, mnack;
    logic        scl_rise, scl_fall, start_c, stop_c, addr_hit, byte_in_done;

    assign scl_rise     = scl_s & ~scl_d;
    assign scl_fall     = ~scl_s & scl_d;
    assign start_c      = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_c       = scl_s & scl_d & ~sda_d & sda_s;
    assign addr_hit     = (shreg[7:1] == {DEV_BASE[6:SEL_W], dev_sel});
    assign byte_in_done = scl_fall && (cnt == BITS_PER_BYTE);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     nxt = ST_IDLE;
            ST_ADDR:     if (byte_in_done) nxt = addr_hit ? ST_ADDR_ACK : ST_IDLE;
            ST_ADDR_ACK: if (scl_fall) nxt = rw ? ST_RD_BYTE : ST_WR_BYTE;
            ST_WR_BYTE:  if (byte_in_done) nxt = ST_WR_ACK;
            ST_WR_ACK:   if (scl_fall) nxt = ST_WR_BYTE;
            ST_RD_BYTE:  if (scl_fall && cnt == LAST_TX_BIT) nxt = ST_RD_ACK;
            ST_RD_ACK:   if (scl_fall) nxt = mnack ? ST_IDLE : ST_RD_BYTE;
            default:     nxt = ST_IDLE;
        endcase
        if (start_c)     nxt = ST_ADDR;
        else if (stop_c) nxt = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // shift, count and pointer datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d     <= 1'b1;
            sda_d     <= 1'b1;
            cnt       <= '0;
            shreg     <= '0;
            tx        <= '0;
            ptr       <= '0;
            rw        <= 1'b0;
            ptr_phase <= 1'b0;
            mnack     <= 1'b0;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
            if (start_c) begin
                cnt <= '0;
            end else begin
                unique case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            shreg <= {shreg[6:0], sda_s};
                            cnt   <= cnt + 4'd1;
                        end
                        if (byte_in_done) begin
                            rw  <= shreg[0];
                            cnt <= '0;
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (rw) begin
                                tx  <= rd_data;
                                ptr <= ptr + 8'd1;
                            end else begin
                                ptr_phase <= 1'b1;
                            end
                        end
                    end
                    ST_WR_BYTE: begin
                        if (scl_rise) begin
                            shreg <= {shreg[6:0], sda_s};
                            cnt   <= cnt + 4'd1;
                        end
                        if (byte_in_done) begin
                            cnt <= '0;
                            if (ptr_phase) begin
                                ptr       <= shreg;
                                ptr_phase <= 1'b0;
                            end else begin
                                ptr <= ptr + 8'd1;
                            end
                        end
                    end
                    ST_RD_BYTE: begin
                        if (scl_fall) begin
                            if (cnt == LAST_TX_BIT) begin
                                cnt <= '0;
                            end else begin
                                tx  <= {tx[6:0], 1'b0};
                                cnt <= cnt + 4'd1;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) mnack <= sda_s;
                        if (scl_fall && !mnack) begin
                            tx  <= rd_data;
                            ptr <= ptr + 8'd1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        wr_en   = (state == ST_WR_BYTE) && byte_in_done && !ptr_phase;
        wr_addr = ptr;
        wr_data = shreg;
        rd_addr = ptr;
        unique case (state)
            ST_ADDR_ACK, ST_WR_ACK: sda_low = 1'b1;
            ST_RD_BYTE:             sda_low = ~tx[7];
            default:                sda_low = 1'b0;
        endcase
    end

    AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        start_c |=> (state == ST_ADDR && cnt == 4'd0)); // R8

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_c && !start_c) |=> (state == ST_IDLE)); // R8

    AST_ACK_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK && $past(state) == ST_ADDR) |->
            (shreg[7:1] == {DEV_BASE[6:SEL_W], dev_sel})); // R2

    AST_WRITE_STEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ptr == $past(ptr) + 8'd1)); // R4

    AST_READ_STEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_ACK && scl_fall && !mnack && !start_c && !stop_c) |=>
            (ptr == $past(ptr) + 8'd1 && state == ST_RD_BYTE)); // R6

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_ADDR) |-> !sda_low); // R9
endmodule

// File: rtl/vcfg_i2c_regs.sv
module vcfg_i2c_regs
    import vcfg_pkg::*;
#(
    parameter logic [6:0] DEV_BASE    = 7'h4C,
    parameter int         SEL_W       = 2,
    parameter int         SYNC_STAGES = 2,
    parameter int         OFST_W      = 6,
    parameter logic [7:0] RST_VAL     = 8'h80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [SEL_W-1:0] dev_sel,
    output logic             sda_pull_low,
    output logic [7:0]       gain_r,
    output logic [7:0]       gain_g,
    output logic [7:0]       gain_b,
    output logic [OFST_W-1:0] ofst_r,
    output logic [OFST_W-1:0] ofst_g,
    output logic [OFST_W-1:0] ofst_b,
    output logic [7:0]       clamp_start,
    output logic [7:0]       clamp_len
);
    logic                     scl_s, sda_s;
    logic                     wr_en;
    logic [7:0]               wr_addr, wr_data, rd_addr, rd_data;
    logic [NCH*BYTE_W-1:0]    gain_bus;
    logic [NCH*OFST_W-1:0]    ofst_bus;

    vcfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));

    vcfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

    vcfg_link #(.DEV_BASE(DEV_BASE), .SEL_W(SEL_W)) u_link (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .dev_sel(dev_sel), .rd_data(rd_data), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .sda_low(sda_pull_low));

    vcfg_regfile #(.OFST_W(OFST_W), .RST_VAL(RST_VAL)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .gain_bus(gain_bus), .ofst_bus(ofst_bus),
        .clamp_pos(clamp_start), .clamp_len(clamp_len));

    assign gain_r = gain_bus[0*BYTE_W +: BYTE_W];
    assign gain_g = gain_bus[1*BYTE_W +: BYTE_W];
    assign gain_b = gain_bus[2*BYTE_W +: BYTE_W];
    assign ofst_r = ofst_bus[0*OFST_W +: OFST_W];
    assign ofst_g = ofst_bus[1*OFST_W +: OFST_W];
    assign ofst_b = ofst_bus[2*OFST_W +: OFST_W];
endmodule

// File: tb/vcfg_i2c_regs_bench.sv
module vcfg_i2c_regs_bench;
    localparam int Q = 5;
    localparam logic [4:0] ADDR_HI = 5'b10011;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_h = 1'b1;
    logic sda_h = 1'b1;
    logic [1:0] dev_sel = 2'b10;
    logic sda_pull_low;
    logic [7:0] gain_r, gain_g, gain_b, clamp_start, clamp_len;
    logic [5:0] ofst_r, ofst_g, ofst_b;
    wire sda_w = sda_h & ~sda_pull_low;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit watch_low = 1'b0;
    bit low_seen = 1'b0;
    logic [7:0] mdl [2:9];
    logic [7:0] wbuf [0:15];

    always #5 clk = ~clk;

    vcfg_i2c_regs u_vcfg_i2c_regs (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_w),
        .dev_sel(dev_sel), .sda_pull_low(sda_pull_low),
        .gain_r(gain_r), .gain_g(gain_g), .gain_b(gain_b),
        .ofst_r(ofst_r), .ofst_g(ofst_g), .ofst_b(ofst_b),
        .clamp_start(clamp_start), .clamp_len(clamp_len));

    always @(posedge clk) if (watch_low && sda_pull_low) low_seen = 1'b1;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mdl_rd(input logic [7:0] p);
        if (p >= 8'h02 && p <= 8'h09) return mdl[p[3:0]];
        return 8'h00;
    endfunction

    task automatic mdl_wr(input logic [7:0] p, input logic [7:0] d);
        if (p >= 8'h05 && p <= 8'h07) mdl[p[3:0]] = d & 8'hFC;
        else if (p >= 8'h02 && p <= 8'h09) mdl[p[3:0]] = d;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_h = 1'b1; tick(Q);
        scl_h = 1'b1; tick(Q);
        sda_h = 1'b0; tick(Q);
        scl_h = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; tick(Q);
        scl_h = 1'b1; tick(Q);
        sda_h = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_h = b[i]; tick(Q);
            scl_h = 1'b1; tick(2*Q);
            scl_h = 1'b0; tick(Q);
        end
        sda_h = 1'b1; tick(Q);
        scl_h = 1'b1; tick(Q);
        ack = ~sda_w; tick(Q);
        scl_h = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        sda_h = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl_h = 1'b1; tick(Q);
            b[i] = sda_w; tick(Q);
            scl_h = 1'b0; tick(Q);
        end
        sda_h = nack; tick(Q);
        scl_h = 1'b1; tick(2*Q);
        scl_h = 1'b0; tick(Q);
        sda_h = 1'b1;
    endtask

    task automatic do_write(input logic [7:0] p, input int n);
        logic ack;
        bus_start();
        send_byte({ADDR_HI, dev_sel, 1'b0}, ack);
        chk("R2 write address ack", {7'd0, ack}, 8'd1);
        send_byte(p, ack);
        chk("R3 pointer byte ack", {7'd0, ack}, 8'd1);
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], ack);
            chk("R4 data byte ack", {7'd0, ack}, 8'd1);
            mdl_wr(p + 8'(k), wbuf[k]);
        end
        bus_stop();
    endtask

    task automatic do_read(input logic [7:0] p, input int n, input string tag);
        logic ack;
        logic [7:0] b;
        bus_start();
        send_byte({ADDR_HI, dev_sel, 1'b0}, ack);
        send_byte(p, ack);
        bus_start();
        send_byte({ADDR_HI, dev_sel, 1'b1}, ack);
        chk("R8 repeated start read ack", {7'd0, ack}, 8'd1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k == n - 1, b);
            chk(tag, b, mdl_rd(p + 8'(k)));
        end
        bus_stop();
    endtask

    task automatic check_outs(input string ctx);
        chk({"R4 gain_r ", ctx}, gain_r, mdl[2]);
        chk({"R4 gain_g ", ctx}, gain_g, mdl[3]);
        chk({"R4 gain_b ", ctx}, gain_b, mdl[4]);
        chk({"R5 ofst_r ", ctx}, {2'b00, ofst_r}, {2'b00, mdl[5][7:2]});
        chk({"R5 ofst_g ", ctx}, {2'b00, ofst_g}, {2'b00, mdl[6][7:2]});
        chk({"R5 ofst_b ", ctx}, {2'b00, ofst_b}, {2'b00, mdl[7][7:2]});
        chk({"R4 clamp_start ", ctx}, clamp_start, mdl[8]);
        chk({"R4 clamp_len ", ctx}, clamp_len, mdl[9]);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic ack;
        for (int r = 2; r <= 9; r++) mdl[r] = 8'h80;
        tick(4);
        rst_n = 1'b1;
        tick(4);

        // R1: reset values at the ports and through a read
        check_outs("R1 reset");
        chk("R1 sda released after reset", {7'd0, sda_pull_low}, 8'd0);
        do_read(8'h02, 8, "R1 reset readback");

        // R4 R5 R7: burst from an unmapped pointer across the whole map and beyond
        for (int k = 0; k < 10; k++) wbuf[k] = 8'(8'h5A + 8'(k * 29));
        do_write(8'h01, 10);
        check_outs("burst from 01h");
        do_read(8'h01, 10, "R5 R7 burst readback");

        // all zeros, then all ones written one register at a time
        for (int k = 0; k < 8; k++) wbuf[k] = 8'h00;
        do_write(8'h02, 8);
        check_outs("all zeros");
        for (int p = 2; p <= 9; p++) begin
            wbuf[0] = 8'hFF;
            do_write(8'(p), 1);
        end
        check_outs("all ones");
        do_read(8'h05, 3, "R5 offset low bits read as zero");

        // R6 R7: read sweep of the entire pointer space with wrap-around
        for (int k = 0; k < 8; k++) wbuf[k] = 8'(8'h11 * (k + 1));
        do_write(8'h02, 8);
        do_read(8'h00, 260, "R6 R7 full pointer sweep");

        // R2: every select value, matching and neighbouring address
        for (int s = 0; s < 4; s++) begin
            dev_sel = 2'(s);
            bus_start();
            send_byte({ADDR_HI, 2'(s), 1'b0}, ack);
            chk("R2 select match ack", {7'd0, ack}, 8'd1);
            bus_stop();
            bus_start();
            send_byte({ADDR_HI, 2'(s + 1), 1'b0}, ack);
            chk("R2 select mismatch nack", {7'd0, ack}, 8'd0);
            bus_stop();
        end

        // R2 R9: sweep of all 7-bit addresses
        dev_sel = 2'b10;
        for (int a = 0; a < 128; a++) begin
            bus_start();
            watch_low = 1'b1;
            low_seen = 1'b0;
            send_byte({7'(a), 1'b0}, ack);
            if (7'(a) == {ADDR_HI, 2'b10}) begin
                chk("R2 sweep match ack", {7'd0, ack}, 8'd1);
                watch_low = 1'b0;
            end else begin
                chk("R2 sweep mismatch nack", {7'd0, ack}, 8'd0);
                send_byte(8'h02, ack);
                chk("R2 ignored byte nack", {7'd0, ack}, 8'd0);
                watch_low = 1'b0;
                chk("R9 no pull-low for foreign address", {7'd0, low_seen}, 8'd0);
            end
            bus_stop();
        end
        check_outs("R2 after address sweep");

        // R8: STOP in the middle of a data byte discards it
        bus_start();
        send_byte({ADDR_HI, 2'b10, 1'b0}, ack);
        send_byte(8'h09, ack);
        for (int i = 0; i < 4; i++) begin
            sda_h = 1'b0; tick(Q);
            scl_h = 1'b1; tick(2*Q);
            scl_h = 1'b0; tick(Q);
        end
        bus_stop();
        chk("R8 partial byte discarded", clamp_len, mdl[9]);
        wbuf[0] = 8'h3C;
        do_write(8'h09, 1);
        chk("R8 transfer after stop", clamp_len, 8'h3C);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule